// File: doc/BRIEF.md
# Program Memory Download Port

This block gives a host a single 32-bit control word through which it fills the byte-wide program RAM of an embedded microcontroller and then reads the RAM back to check it. A write carries a command byte in [31:24], a data byte in [23:16] and a byte address in [13:0]. While the upload command is in force the core's reset output is held, and every upload write stores its data byte at its address. A read returns the latched command byte, the byte stored at the current address and that address. The address then steps by one and wraps at the end of the RAM, so the host can keep reading until it sees address zero and then stream a full verification pass.

Two further commands end the load. One releases the core from reset. The other releases it as well and also flags the image as verified. Host requests enter on a valid/ready channel. Read results leave on a second valid/ready channel. While a read result waits for `rsp_ready`, the request channel drops `req_ready`, so at most one result is ever outstanding. A result holds its value until it is taken.

Top module: `fwdl_port`

## Requirements
- R1: After reset, `core_hold` is 1, `image_verified` is 0, `rsp_valid` is 0 and `req_ready` is 1. The command byte reads back as 0x00.
- R2: A write whose command byte [31:24] is 0x0F stores the data byte [23:16] at the RAM address given by the write. After it, `core_hold` is 1.
- R3: A read result is {command byte in [31:24], stored byte in [23:16], 2'b00 in [15:14], address zero-extended in [13:0]}. After each read the address advances by one.
- R4: The address counter wraps from 2^AW-1 to 0 (AW = 10 by default).
- R5: A write whose command byte is not 0x0F leaves the RAM contents unchanged. It still loads the command byte and the address.
- R6: `core_hold` stays 1 from reset until a write with command 0x03 or 0x13. Command 0x03 drops it to 0.
- R7: Command 0x13 sets `image_verified` and drops `core_hold`. Command 0x0F sets `core_hold` and clears `image_verified`.
- R8: A read issued right after a write returns that write's data byte and address.
- R9: While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_rdata` holds steady. While `rsp_valid` is 1, `req_ready` is 0.
- R10: Write address bits [15:14], and any bits at or above AW, are ignored. They select no location and do not appear in the read-back address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write word {command, data, address} |
| rsp_valid | output | 1 | Read result present |
| rsp_ready | input | 1 | Host takes the read result |
| rsp_rdata | output | 32 | Read result {command, byte, 00, address} |
| core_hold | output | 1 | Reset to the microcontroller core |
| image_verified | output | 1 | Loaded image marked verified |

## Verification
The checker watches the handshake rules on every cycle: a pending result holds steady and blocks new requests, every accepted read yields a result, and the result's pad bits are zero. It also checks how the command codes move `core_hold` and `image_verified`. The RAM contents cannot be seen by a per-cycle property, so only the bench's scenarios show them. These scenarios cover stored bytes, read-after-write, wrap to zero, non-upload writes that leave memory untouched, and ignored high address bits. The bench compares every read result against its own model of the RAM and the address counter.

// File: rtl/fwdl_pkg.sv
package fwdl_pkg;
  localparam logic [7:0] CMD_UPLOAD   = 8'h0F;
  localparam logic [7:0] CMD_RUN      = 8'h03;
  localparam logic [7:0] CMD_VERIFIED = 8'h13;
  localparam int WORD_W = 32;
  localparam int FIELD_AW = 14;
endpackage

// File: rtl/fwdl_regs.sv
module fwdl_regs
  import fwdl_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_fire,
  input  logic          rd_fire,
  input  logic [31:0]   wword,
  output logic [7:0]    cmd_q,
  output logic [AW-1:0] addr_q,
  output logic          mem_we,
  output logic          hold_q,
  output logic          verif_q
);
  logic [7:0] cmd_in;
  assign cmd_in = wword[31:24];
  assign mem_we = wr_fire && (cmd_in == CMD_UPLOAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q   <= '0;
      addr_q  <= '0;
      hold_q  <= 1'b1;
      verif_q <= 1'b0;
    end else if (wr_fire) begin
      cmd_q  <= cmd_in;
      addr_q <= wword[AW-1:0];
      unique case (cmd_in)
        CMD_UPLOAD:   begin hold_q <= 1'b1; verif_q <= 1'b0; end
        CMD_RUN:      hold_q <= 1'b0;
        CMD_VERIFIED: begin hold_q <= 1'b0; verif_q <= 1'b1; end
        default: ;
      endcase
    end else if (rd_fire) begin
      addr_q <= addr_q + 1'b1;
    end
  end
endmodule

// File: rtl/fwdl_ram.sv
module fwdl_ram #(
  parameter int AW = 10
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wbyte,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rbyte
);
  localparam int DEPTH = 1 << AW;
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wbyte;
    if (re) rbyte <= store[raddr];
  end
endmodule

// File: rtl/fwdl_port.sv
module fwdl_port
  import fwdl_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [31:0] req_wdata,
  output logic        rsp_valid,
  input  logic        rsp_ready,
  output logic [31:0] rsp_rdata,
  output logic        core_hold,
  output logic        image_verified
);
  localparam int PAD_W = FIELD_AW - AW;

  logic          wr_fire, rd_fire, mem_we;
  logic [7:0]    cmd_q, rsp_cmd, ram_q;
  logic [AW-1:0] addr_q, rsp_addr;
  logic [13:0]   addr_field;

  assign req_ready = !rsp_valid;
  assign wr_fire   = req_valid && req_ready && req_write;
  assign rd_fire   = req_valid && req_ready && !req_write;

  fwdl_regs #(.AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
    .wword(req_wdata), .cmd_q(cmd_q), .addr_q(addr_q), .mem_we(mem_we),
    .hold_q(core_hold), .verif_q(image_verified)
  );

  fwdl_ram #(.AW(AW)) u_ram (
    .clk(clk), .we(mem_we), .waddr(req_wdata[AW-1:0]),
    .wbyte(req_wdata[23:16]), .re(rd_fire), .raddr(addr_q), .rbyte(ram_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_cmd   <= '0;
      rsp_addr  <= '0;
    end else if (rd_fire) begin
      rsp_valid <= 1'b1;
      rsp_cmd   <= cmd_q;
      rsp_addr  <= addr_q;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign addr_field = {{PAD_W{1'b0}}, rsp_addr};
    end else begin : g_full
      assign addr_field = rsp_addr;
    end
  endgenerate

  assign rsp_rdata = {rsp_cmd, ram_q, 2'b00, addr_field};
endmodule

// File: rtl/fwdl_port_chk.sv
module fwdl_port_chk #(
  parameter int AW = 10
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_rdata,
  input logic        core_hold,
  input logic        image_verified
);
  logic wr_ok, rd_ok;
  assign wr_ok = req_valid && req_ready && req_write;
  assign rd_ok = req_valid && req_ready && !req_write;

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata));
  p_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  p_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> rsp_valid);
  p_pad_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_rdata[15:14] == 2'b00);
  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_hold) |-> $past(wr_ok && (req_wdata[31:24] == 8'h03 ||
                                         req_wdata[31:24] == 8'h13)));
  p_upload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && req_wdata[31:24] == 8'h0F |=> core_hold && !image_verified);
  p_verified_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ok && req_wdata[31:24] == 8'h13 |=> image_verified && !core_hold);
endmodule

bind fwdl_port fwdl_port_chk #(.AW(AW)) u_chk (.*);

// File: tb/test_fwdl_port.sv
module test_fwdl_port;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid, core_hold, image_verified;
  logic [31:0] rsp_rdata;

  int n_cmp = 0, n_bad = 0;
  logic [7:0]    m_mem [DEPTH];
  logic [7:0]    m_cmd = 8'h00;
  logic [AW-1:0] m_addr = '0;
  logic [31:0]   exp_q[$];
  string         tag_q[$];

  always #5 clk = ~clk;

  fwdl_port #(.AW(AW)) i_fwdl_port (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // monitor: take a result at the negedge before the handshake edge
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R3 unexpected result", rsp_rdata, 32'h0);
      else check(tag_q.pop_front(), rsp_rdata, exp_q.pop_front());
    end
  end

  task automatic issue(logic wr, logic [31:0] w);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_wdata = w;
    while (!req_ready) @(negedge clk);
    if (wr) begin
      m_cmd  = w[31:24];
      m_addr = w[AW-1:0];
      if (w[31:24] == 8'h0F) m_mem[w[AW-1:0]] = w[23:16];
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(logic [7:0] c, logic [7:0] d, logic [15:0] a);
    issue(1'b1, {c, d, a});
  endtask

  task automatic rd(string tag);
    exp_q.push_back({m_cmd, m_mem[m_addr], 2'b00, 4'b0000, m_addr});
    tag_q.push_back(tag);
    m_addr = m_addr + 1'b1;
    issue(1'b0, '0);
  endtask

  task automatic drain;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 core_hold", core_hold, 1);
    check("R1 image_verified", image_verified, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 req_ready", req_ready, 1);

    // R2 upload stores bytes; R8 read right after write
    wr(8'h0F, 8'hA5, 16'h0010);
    check("R2 hold after upload", core_hold, 1);
    rd("R8 read after write at 0x010");
    wr(8'h0F, 8'h3C, 16'h0011);
    rd("R8 read after write at 0x011");
    for (int i = 0; i < 8; i++) wr(8'h0F, 8'(i * 29 + 7), 16'(16'h0040 + i));
    // R3 streaming read with auto-increment
    wr(8'h0F, 8'h07, 16'h0040);
    for (int i = 0; i < 8; i++) rd("R3 streamed read");
    drain();

    // R4 wrap at top of RAM
    wr(8'h0F, 8'h00, 16'h0000);
    wr(8'h0F, 8'hEE, 16'(DEPTH - 1));
    rd("R4 last location");
    rd("R4 wrapped to zero");
    drain();

    // R5 non-upload write leaves RAM untouched
    wr(8'h0F, 8'h5A, 16'h0020);
    wr(8'h22, 8'hFF, 16'h0020);
    rd("R5 other command keeps byte");
    wr(8'h00, 8'h11, 16'h0020);
    rd("R5 zero command keeps byte");
    drain();

    // R10 ignored high address bits
    wr(8'h0F, 8'h77, 16'hFC05);
    rd("R10 high bits ignored");
    wr(8'h0F, 8'h77, 16'h0005);
    rd("R10 plain address");
    drain();

    // R9 back-pressure
    @(posedge clk); #1 rsp_ready = 1'b0;
    wr(8'h0F, 8'h99, 16'h0030);
    rd("R9 result after stall");
    repeat (3) @(negedge clk);
    check("R9 rsp_valid held", rsp_valid, 1);
    check("R9 req_ready low", req_ready, 0);
    check("R9 data held", rsp_rdata, {8'h0F, 8'h99, 16'h0030});
    @(posedge clk); #1 rsp_ready = 1'b1;
    drain();

    // R6 hold stays until release, then 0x03 releases
    wr(8'h44, 8'h00, 16'h0000);
    check("R6 hold kept by other command", core_hold, 1);
    wr(8'h03, 8'h00, 16'(DEPTH));
    check("R6 released by 0x03", core_hold, 0);
    check("R6 not verified", image_verified, 0);
    // R7 verified then re-upload
    wr(8'h13, 8'h00, 16'(DEPTH));
    check("R7 verified set", image_verified, 1);
    check("R7 hold released", core_hold, 0);
    rd("R7 command byte 0x13 reads back");
    drain();
    wr(8'h0F, 8'h12, 16'h0001);
    check("R7 upload re-holds", core_hold, 1);
    check("R7 upload clears verified", image_verified, 0);

    // R1 command reads 0x00 after a fresh reset
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_cmd = 8'h00; m_addr = '0;
    wr(8'h0F, 8'h6B, 16'h0000);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    m_cmd = 8'h00; m_addr = '0;
    rd("R1 command byte 0x00 after reset");
    drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule